// File: doc/BRIEF.md
# Overlay Window Shadow Register Bank

This block keeps the programming state for a set of overlay windows (five by default, numbered 0 to 4) that a display pipeline scans out. Every window field exists twice: a CPU copy that the register port writes and reads, and a shadow copy that drives the pipeline. The shadow copy of a window is refreshed from its CPU copy only on a vertical-sync pulse, so the pipeline never sees a field change in the middle of a frame.

A shared control word holds, for every window, a protect bit and a DMA channel enable. While a window's protect bit is set, vertical sync leaves that window's shadow untouched. Software sets the bit, rewrites start address, end address, corners, line size and alpha in any order, then clears it. The whole set then lands together at the next vertical sync. Other windows keep updating meanwhile.

The register port is a plain single-cycle write port and a combinational read port. Neither can stall, so there is no back-pressure: a write with `cfg_wr_en` high is taken at that clock edge, and `cfg_rdata` follows `cfg_rd_addr` in the same cycle. The shadow outputs are level signals with no handshake.

Top module: `ovl_shadow_bank`

## Requirements
- R1: After reset, every shadow output is zero, every window is disabled, and every readable register returns zero.
- R2: The register address is 7 bits. Address 0 is the control word. Window w occupies addresses `(w+1)*8 + f`, where the field code f is:
  - 0: enable, in bit 0.
  - 1: buffer start address.
  - 2: buffer end address (inclusive byte range).
  - 3: top-left corner, with x in bits 11:0 and y in bits 27:16.
  - 4: bottom-right corner, same packing; it equals offset plus size minus one.
  - 5: line size, with line length in bytes in bits 15:0 and line-to-line skip in bytes in bits 31:16.
  - 6: alpha, in bits 11:0.
  
  A read returns the CPU copy as last written, not the shadow copy.
- R3: Without a vertical-sync pulse, a window's shadow outputs do not change, however its CPU copy is written.
- R4: On a vertical-sync pulse, every unprotected window copies all of its CPU fields to its shadow outputs, visible from the next cycle.
- R5: While a window's protect bit is set, vertical sync leaves that window's shadow unchanged. The pending values transfer at the first vertical sync after the bit is cleared.
- R6: Protection is per window: a protected window does not stop other windows from transferring at the same vertical sync.
- R7: A write to a window field in the same cycle as a vertical-sync pulse puts the value from before that write into the shadow. The new value transfers at the following vertical sync.
- R8: A control-word write in the same cycle as a vertical-sync pulse does not affect that pulse, which uses the protect bits held before the write.
- R9: Window 0 has no alpha. Writes to its alpha field are ignored, reading that field returns zero, and its shadow alpha stays zero.
- R10: The control word holds the protect bit of window w in bit w and the DMA channel enable of window w in bit 16+w. The DMA enable reaches `sh_dma` through the same vertical-sync and protect rules as the other window fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Write address |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_addr | input | 7 | Read address |
| cfg_rdata | output | 32 | Read data (CPU copy), combinational |
| vsync | input | 1 | Single-cycle vertical-sync pulse |
| sh_en | output | NUM_WIN | Shadow window enable |
| sh_dma | output | NUM_WIN | Shadow DMA channel enable |
| sh_start | output | NUM_WIN x 32 | Shadow buffer start address |
| sh_end | output | NUM_WIN x 32 | Shadow buffer end address |
| sh_tl_x | output | NUM_WIN x 12 | Shadow top-left x |
| sh_tl_y | output | NUM_WIN x 12 | Shadow top-left y |
| sh_br_x | output | NUM_WIN x 12 | Shadow bottom-right x |
| sh_br_y | output | NUM_WIN x 12 | Shadow bottom-right y |
| sh_line_len | output | NUM_WIN x 16 | Shadow line length in bytes |
| sh_skip | output | NUM_WIN x 16 | Shadow line-to-line skip in bytes |
| sh_alpha | output | NUM_WIN x 12 | Shadow alpha (zero for window 0) |

## Verification
Register writes and vertical sync can land on the same clock edge. That happens in two ways: a window field is rewritten at the very edge of the sync pulse, or the control word that sets or clears a protect bit is written at that edge. The bench drives both strobes in one cycle. It then checks three things: the shadow holds the pre-write field value, the readback already shows the new one, and the decision to transfer or hold follows the protect bits held before the control write. A further sync then proves that the deferred value arrives.

// File: rtl/ovl_shadow_pkg.sv
package ovl_shadow_pkg;
  parameter int DATA_W   = 32;
  parameter int BADDR_W  = 32;
  parameter int CRD_W    = 12;
  parameter int LEN_W    = 16;
  parameter int ALPHA_W  = 12;
  parameter int REG_AW   = 7;
  parameter int FLD_W    = 3;
  parameter int HI_LSB   = 16;  // upper half-word of packed fields
  parameter int DMA_LSB  = 16;  // control word: DMA enables start here

  localparam int WSEL_W  = REG_AW - FLD_W;

  localparam logic [FLD_W-1:0] F_ENABLE   = 3'd0;
  localparam logic [FLD_W-1:0] F_START    = 3'd1;
  localparam logic [FLD_W-1:0] F_END      = 3'd2;
  localparam logic [FLD_W-1:0] F_TOPLEFT  = 3'd3;
  localparam logic [FLD_W-1:0] F_BOTRIGHT = 3'd4;
  localparam logic [FLD_W-1:0] F_SIZE     = 3'd5;
  localparam logic [FLD_W-1:0] F_ALPHA    = 3'd6;

  typedef struct packed {
    logic               en;
    logic [BADDR_W-1:0] start_a;
    logic [BADDR_W-1:0] end_a;
    logic [CRD_W-1:0]   tl_x;
    logic [CRD_W-1:0]   tl_y;
    logic [CRD_W-1:0]   br_x;
    logic [CRD_W-1:0]   br_y;
    logic [LEN_W-1:0]   line_len;
    logic [LEN_W-1:0]   skip;
    logic [ALPHA_W-1:0] alpha;
  } win_cfg_t;
endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg
  import ovl_shadow_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_WIN-1:0] prot,
  output logic [NUM_WIN-1:0] dma
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot <= '0;
      dma  <= '0;
    end else if (wr_hit) begin
      prot <= wdata[NUM_WIN-1:0];
      dma  <= wdata[DMA_LSB +: NUM_WIN];
    end
  end
endmodule

// File: rtl/ovl_win_slot.sv
module ovl_win_slot
  import ovl_shadow_pkg::*;
#(
  parameter bit HAS_ALPHA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [FLD_W-1:0]  fld,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vsync,
  input  logic              prot,
  input  logic              dma_cpu,
  output win_cfg_t          cpu_cfg,
  output win_cfg_t          sh_cfg,
  output logic              sh_dma
);
  logic load;
  assign load = vsync && !prot;

  // CPU-visible copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_cfg <= '0;
    end else if (wr_hit) begin
      case (fld)
        F_ENABLE:   cpu_cfg.en      <= wdata[0];
        F_START:    cpu_cfg.start_a <= wdata[BADDR_W-1:0];
        F_END:      cpu_cfg.end_a   <= wdata[BADDR_W-1:0];
        F_TOPLEFT: begin
          cpu_cfg.tl_x <= wdata[CRD_W-1:0];
          cpu_cfg.tl_y <= wdata[HI_LSB +: CRD_W];
        end
        F_BOTRIGHT: begin
          cpu_cfg.br_x <= wdata[CRD_W-1:0];
          cpu_cfg.br_y <= wdata[HI_LSB +: CRD_W];
        end
        F_SIZE: begin
          cpu_cfg.line_len <= wdata[LEN_W-1:0];
          cpu_cfg.skip     <= wdata[HI_LSB +: LEN_W];
        end
        F_ALPHA: begin
          if (HAS_ALPHA) cpu_cfg.alpha <= wdata[ALPHA_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // Shadow copy, frame-latched
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_cfg <= '0;
      sh_dma <= 1'b0;
    end else if (load) begin
      sh_cfg <= cpu_cfg;
      sh_dma <= dma_cpu;
    end
  end
endmodule

// File: rtl/ovl_rd_mux.sv
module ovl_rd_mux
  import ovl_shadow_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input  logic [REG_AW-1:0]           rd_addr,
  input  logic [NUM_WIN-1:0]          prot,
  input  logic [NUM_WIN-1:0]          dma,
  input  win_cfg_t [NUM_WIN-1:0]      cpu_cfg,
  output logic [DATA_W-1:0]           rdata
);
  logic [WSEL_W-1:0] wsel;
  logic [FLD_W-1:0]  fld;
  win_cfg_t          pick;
  logic              hit;

  assign wsel = rd_addr[REG_AW-1:FLD_W];
  assign fld  = rd_addr[FLD_W-1:0];

  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (wsel == WSEL_W'(w + 1)) begin
        pick = cpu_cfg[w];
        hit  = 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_addr == '0) begin
      rdata[NUM_WIN-1:0]          = prot;
      rdata[DMA_LSB +: NUM_WIN]   = dma;
    end else if (hit) begin
      case (fld)
        F_ENABLE:   rdata[0] = pick.en;
        F_START:    rdata[BADDR_W-1:0] = pick.start_a;
        F_END:      rdata[BADDR_W-1:0] = pick.end_a;
        F_TOPLEFT: begin
          rdata[CRD_W-1:0]       = pick.tl_x;
          rdata[HI_LSB +: CRD_W] = pick.tl_y;
        end
        F_BOTRIGHT: begin
          rdata[CRD_W-1:0]       = pick.br_x;
          rdata[HI_LSB +: CRD_W] = pick.br_y;
        end
        F_SIZE: begin
          rdata[LEN_W-1:0]       = pick.line_len;
          rdata[HI_LSB +: LEN_W] = pick.skip;
        end
        F_ALPHA:    rdata[ALPHA_W-1:0] = pick.alpha;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ovl_shadow_bank.sv
module ovl_shadow_bank
  import ovl_shadow_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_wr_en,
  input  logic [REG_AW-1:0]                 cfg_addr,
  input  logic [DATA_W-1:0]                 cfg_wdata,
  input  logic [REG_AW-1:0]                 cfg_rd_addr,
  output logic [DATA_W-1:0]                 cfg_rdata,
  input  logic                              vsync,
  output logic [NUM_WIN-1:0]                sh_en,
  output logic [NUM_WIN-1:0]                sh_dma,
  output logic [NUM_WIN-1:0][BADDR_W-1:0]   sh_start,
  output logic [NUM_WIN-1:0][BADDR_W-1:0]   sh_end,
  output logic [NUM_WIN-1:0][CRD_W-1:0]     sh_tl_x,
  output logic [NUM_WIN-1:0][CRD_W-1:0]     sh_tl_y,
  output logic [NUM_WIN-1:0][CRD_W-1:0]     sh_br_x,
  output logic [NUM_WIN-1:0][CRD_W-1:0]     sh_br_y,
  output logic [NUM_WIN-1:0][LEN_W-1:0]     sh_line_len,
  output logic [NUM_WIN-1:0][LEN_W-1:0]     sh_skip,
  output logic [NUM_WIN-1:0][ALPHA_W-1:0]   sh_alpha
);
  localparam int MAX_WIN = (1 << WSEL_W) - 1;

  initial begin
    if (NUM_WIN < 1 || NUM_WIN > MAX_WIN || NUM_WIN > DATA_W - DMA_LSB)
      $error("NUM_WIN out of range");
  end

  logic [NUM_WIN-1:0]               prot_q;
  logic [NUM_WIN-1:0]               dma_q;
  logic [NUM_WIN-1:0]               win_hit;
  logic                             ctrl_hit;
  logic [WSEL_W-1:0]                wr_wsel;
  win_cfg_t [NUM_WIN-1:0]           cpu_cfg;
  win_cfg_t [NUM_WIN-1:0]           sh_cfg;
  logic [NUM_WIN-1:0][BADDR_W-1:0]  cpu_start_w;

  assign wr_wsel  = cfg_addr[REG_AW-1:FLD_W];
  assign ctrl_hit = cfg_wr_en && (cfg_addr == '0);

  ovl_ctrl_reg #(.NUM_WIN(NUM_WIN)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_hit(ctrl_hit),
    .wdata (cfg_wdata),
    .prot  (prot_q),
    .dma   (dma_q)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_hit[w] = cfg_wr_en && (wr_wsel == WSEL_W'(w + 1));

    ovl_win_slot #(.HAS_ALPHA(w != 0)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (win_hit[w]),
      .fld    (cfg_addr[FLD_W-1:0]),
      .wdata  (cfg_wdata),
      .vsync  (vsync),
      .prot   (prot_q[w]),
      .dma_cpu(dma_q[w]),
      .cpu_cfg(cpu_cfg[w]),
      .sh_cfg (sh_cfg[w]),
      .sh_dma (sh_dma[w])
    );

    assign cpu_start_w[w] = cpu_cfg[w].start_a;
    assign sh_en[w]       = sh_cfg[w].en;
    assign sh_start[w]    = sh_cfg[w].start_a;
    assign sh_end[w]      = sh_cfg[w].end_a;
    assign sh_tl_x[w]     = sh_cfg[w].tl_x;
    assign sh_tl_y[w]     = sh_cfg[w].tl_y;
    assign sh_br_x[w]     = sh_cfg[w].br_x;
    assign sh_br_y[w]     = sh_cfg[w].br_y;
    assign sh_line_len[w] = sh_cfg[w].line_len;
    assign sh_skip[w]     = sh_cfg[w].skip;
    assign sh_alpha[w]    = sh_cfg[w].alpha;
  end

  ovl_rd_mux #(.NUM_WIN(NUM_WIN)) u_rd (
    .rd_addr(cfg_rd_addr),
    .prot   (prot_q),
    .dma    (dma_q),
    .cpu_cfg(cpu_cfg),
    .rdata  (cfg_rdata)
  );
endmodule

// File: rtl/ovl_shadow_chk.sv
module ovl_shadow_chk
  import ovl_shadow_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             vsync,
  input logic                             cfg_wr_en,
  input logic [REG_AW-1:0]                cfg_addr,
  input logic [DATA_W-1:0]                cfg_wdata,
  input logic [NUM_WIN-1:0]               prot_q,
  input logic [NUM_WIN-1:0][BADDR_W-1:0]  cpu_start_w,
  input logic [NUM_WIN-1:0][BADDR_W-1:0]  sh_start,
  input logic [NUM_WIN-1:0]               sh_en
);
  // R1: shadow enables are clear on the first edge after reset release
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (sh_en == '0));

  // R10: control write lands in the protect bits
  assert_ctrl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_addr == '0) |=> (prot_q == $past(cfg_wdata[NUM_WIN-1:0])));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
    // R3, R5: no unprotected vsync means the shadow holds
    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(vsync && !prot_q[w]) |=> ($stable(sh_start[w]) && $stable(sh_en[w])));

    // R4, R7: unprotected vsync copies the CPU value held before the edge
    assert_shadow_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !prot_q[w]) |=> (sh_start[w] == $past(cpu_start_w[w])));
  end
endmodule

bind ovl_shadow_bank ovl_shadow_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vsync      (vsync),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .prot_q     (prot_q),
  .cpu_start_w(cpu_start_w),
  .sh_start   (sh_start),
  .sh_en      (sh_en)
);

// File: tb/ovl_shadow_bank_bench.sv
`timescale 1ns/1ps
module ovl_shadow_bank_bench;
  localparam int NW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [6:0] cfg_rd_addr = '0;
  logic [31:0] cfg_rdata;
  logic vsync = 1'b0;
  logic [NW-1:0] sh_en, sh_dma;
  logic [NW-1:0][31:0] sh_start, sh_end;
  logic [NW-1:0][11:0] sh_tl_x, sh_tl_y, sh_br_x, sh_br_y, sh_alpha;
  logic [NW-1:0][15:0] sh_line_len, sh_skip;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ovl_shadow_bank #(.NUM_WIN(NW)) u_ovl_shadow_bank (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rd_addr(cfg_rd_addr), .cfg_rdata(cfg_rdata),
    .vsync(vsync), .sh_en(sh_en), .sh_dma(sh_dma), .sh_start(sh_start),
    .sh_end(sh_end), .sh_tl_x(sh_tl_x), .sh_tl_y(sh_tl_y), .sh_br_x(sh_br_x),
    .sh_br_y(sh_br_y), .sh_line_len(sh_line_len), .sh_skip(sh_skip),
    .sh_alpha(sh_alpha)
  );

  function automatic logic [6:0] wa(input int w, input int f);
    return 7'(((w + 1) << 3) | f);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  // one write, optionally together with a vsync pulse in the same cycle
  task automatic wr(input logic [6:0] a, input logic [31:0] d, input bit with_vs);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d; vsync = with_vs;
    @(negedge clk);
    cfg_wr_en = 1'b0; vsync = 1'b0;
  endtask

  task automatic pulse_vs();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    cfg_rd_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "sh_en", 32'(sh_en), 0);
    chk("R1", "sh_dma", 32'(sh_dma), 0);
    chk("R1", "sh_start[1]", sh_start[1], 0);
    chk("R1", "sh_br_x[4]", 32'(sh_br_x[4]), 0);
    rd(7'd0, d);      chk("R1", "ctrl read", d, 0);
    rd(wa(2, 2), d);  chk("R1", "win2 end read", d, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(wa(1, 1), 32'h1000_0000, 0);
    wr(wa(1, 2), 32'h1000_1FFF, 0);
    wr(wa(1, 3), 32'h0005_0003, 0);
    wr(wa(1, 4), 32'h0024_0042, 0);
    wr(wa(1, 5), 32'h0040_0100, 0);
    wr(wa(1, 6), 32'h0000_0ABC, 0);
    wr(wa(1, 0), 32'h1, 0);
    rd(wa(1, 1), d); chk("R2", "win1 start read", d, 32'h1000_0000);
    rd(wa(1, 3), d); chk("R2", "win1 topleft read", d, 32'h0005_0003);
    rd(wa(1, 5), d); chk("R2", "win1 size read", d, 32'h0040_0100);
    repeat (3) @(negedge clk);
    chk("R3", "win1 start before vsync", sh_start[1], 0);
    chk("R3", "win1 en before vsync", 32'(sh_en[1]), 0);
    pulse_vs();
    chk("R4", "sh_en[1]", 32'(sh_en[1]), 1);
    chk("R4", "sh_start[1]", sh_start[1], 32'h1000_0000);
    chk("R4", "sh_end[1]", sh_end[1], 32'h1000_1FFF);
    chk("R4", "sh_tl_x[1]", 32'(sh_tl_x[1]), 3);
    chk("R4", "sh_tl_y[1]", 32'(sh_tl_y[1]), 5);
    chk("R4", "sh_br_x[1]", 32'(sh_br_x[1]), 32'h42);
    chk("R4", "sh_br_y[1]", 32'(sh_br_y[1]), 32'h24);
    chk("R4", "sh_line_len[1]", 32'(sh_line_len[1]), 32'h100);
    chk("R4", "sh_skip[1]", 32'(sh_skip[1]), 32'h40);
    chk("R4", "sh_alpha[1]", 32'(sh_alpha[1]), 32'hABC);
    // readback shows CPU copy after a later write, shadow unchanged
    wr(wa(1, 2), 32'h2000_0000, 0);
    rd(wa(1, 2), d); chk("R2", "read returns CPU copy", d, 32'h2000_0000);
    chk("R3", "shadow end after write", sh_end[1], 32'h1000_1FFF);
  endtask

  task automatic t_protect();
    wr(7'd0, 32'h0000_0004, 0);           // protect window 2
    wr(wa(2, 1), 32'h0000_B000, 0);
    wr(wa(3, 1), 32'h0000_C000, 0);
    pulse_vs();
    chk("R5", "protected win2 held", sh_start[2], 0);
    chk("R6", "unprotected win3 loads", sh_start[3], 32'h0000_C000);
    wr(7'd0, 32'h0, 0);                   // release
    repeat (2) @(negedge clk);
    chk("R5", "win2 waits for vsync after release", sh_start[2], 0);
    pulse_vs();
    chk("R5", "win2 loads after release", sh_start[2], 32'h0000_B000);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(wa(1, 1), 32'h0000_D000, 1);       // write and vsync same cycle
    chk("R7", "shadow keeps pre-write value", sh_start[1], 32'h1000_0000);
    rd(wa(1, 1), d); chk("R7", "readback has new value", d, 32'h0000_D000);
    pulse_vs();
    chk("R7", "new value at next vsync", sh_start[1], 32'h0000_D000);
  endtask

  task automatic t_prot_edge();
    wr(wa(4, 1), 32'h0000_E000, 0);
    wr(7'd0, 32'h0000_0010, 1);           // set protect with vsync
    chk("R8", "set-protect edge still loads", sh_start[4], 32'h0000_E000);
    wr(wa(4, 1), 32'h0000_F000, 0);
    wr(7'd0, 32'h0, 1);                   // clear protect with vsync
    chk("R8", "clear-protect edge still holds", sh_start[4], 32'h0000_E000);
    pulse_vs();
    chk("R8", "loads at following vsync", sh_start[4], 32'h0000_F000);
  endtask

  task automatic t_win0();
    logic [31:0] d;
    wr(wa(0, 6), 32'h0000_0ABC, 0);
    wr(wa(0, 1), 32'h0000_0A00, 0);
    rd(wa(0, 6), d); chk("R9", "win0 alpha reads zero", d, 0);
    pulse_vs();
    chk("R9", "win0 shadow alpha zero", 32'(sh_alpha[0]), 0);
    chk("R9", "win0 start still loads", sh_start[0], 32'h0000_0A00);
  endtask

  task automatic t_dma();
    logic [31:0] d;
    wr(7'd0, 32'h0002_0002, 0);           // dma win1 on, protect win1
    rd(7'd0, d); chk("R10", "ctrl readback", d, 32'h0002_0002);
    chk("R10", "dma not yet shadowed", 32'(sh_dma), 0);
    pulse_vs();
    chk("R10", "dma held while protected", 32'(sh_dma), 0);
    wr(7'd0, 32'h0002_0000, 0);
    pulse_vs();
    chk("R10", "dma reaches shadow", 32'(sh_dma), 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_protect();
    t_collide();
    t_prot_edge();
    t_win0();
    t_dma();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule